// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds stores between the point where they finish execution and the point where memory is updated. A store claims a slot in program order when it is dispatched and receives a slot tag. Later, once its address has been translated, the same tag delivers the word address, the data and the byte enables. When the reorder buffer completes the oldest pending store, that store is marked committed. Committed stores leave from the head of the buffer one at a time, and each one leaves only when the memory write port grants it. The buffer therefore updates memory strictly in program order and never ahead of completion.

Every load is compared against all stores the buffer holds, and every held store is older than the load. The comparison has three possible results. The load can take the data of the youngest matching store, and then no memory read is issued. The load can go to memory ahead of the pending stores when nothing aliases. The load stalls when aliasing cannot be settled, either because some held store has no address yet or because the youngest match covers only part of the bytes the load wants. A pipeline flush throws away every store that has not been committed and keeps the committed ones, which still drain.

Top module: `store_buffer_fwd`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `mem_wr_valid` is 0, `alloc_tag` is 0, and any load is sent to memory (`mem_rd_valid`=1).
- R2: `alloc_ready` is 0 while DEPTH stores are held. An `alloc_valid` in that state is ignored, and `alloc_tag` keeps its value.
- R3: `mem_wr_valid` presents the oldest held store (address, data, byte enables). These values do not change until `mem_wr_grant` is seen, and the store is removed in the cycle of the grant.
- R4: `mem_wr_valid` is 1 exactly when at least one committed store is held. An uncommitted store never reaches the write port.
- R5: A load (`ld_valid`=1) for which every held store has an address, and none matches, drives `mem_rd_valid`=1 with `mem_rd_addr`=`ld_addr` and `mem_rd_be`=`ld_be`. Exactly one of `ld_fwd_valid`, `mem_rd_valid`, `ld_stall` is 1 for each load, and all three are 0 without a load.
- R6: A store matches a load when the word addresses are equal and the two byte-enable sets share at least one bit. If the youngest matching store's enables include every load enable bit, the result is `ld_fwd_valid`=1 and `mem_rd_valid`=0. `ld_fwd_data` then carries that store's bytes in the enabled lanes (byte i is bits 8i+7..8i) and zero in the other lanes.
- R7: When several held stores match, the data comes from the youngest one, which is the one allocated last.
- R8: When any held store has not yet received its address, every load stalls (`ld_stall`=1, no read, no forward).
- R9: When the youngest matching store lacks some of the load's enabled bytes, the load stalls.
- R10: `flush` removes every uncommitted store and keeps the committed stores, which stay in order. The next `alloc_tag` becomes the slot after the newest committed store. `alloc_valid` and `commit_valid` are ignored in the flush cycle.
- R11: `commit_valid` is ignored unless the oldest uncommitted store already has its address and data.
- R12: A store at the same word address whose byte enables do not overlap the load's enables does not match, so the load is not stalled or forwarded because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Reserve a slot for the next store in program order |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | PW | Slot the next allocation receives |
| fill_valid | input | 1 | Translated address and data arrive for a slot |
| fill_tag | input | PW | Slot being filled |
| fill_addr | input | AW | Word address of the store |
| fill_data | input | DW | Store data |
| fill_be | input | BW | Store byte enables |
| commit_valid | input | 1 | Oldest uncommitted store has completed |
| flush | input | 1 | Discard all uncommitted stores |
| ld_valid | input | 1 | A load is presented |
| ld_addr | input | AW | Load word address |
| ld_be | input | BW | Load byte enables |
| ld_fwd_valid | output | 1 | Load served from the buffer |
| ld_fwd_data | output | DW | Forwarded data, unused lanes zero |
| ld_stall | output | 1 | Load must retry |
| mem_rd_valid | output | 1 | Load goes to memory |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_be | output | BW | Memory read byte enables |
| mem_wr_valid | output | 1 | Oldest committed store is ready to write |
| mem_wr_grant | input | 1 | Memory accepts the write this cycle |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| mem_wr_be | output | BW | Write byte enables |

## Verification
A head pointer that has gone wrong shows up on the write port in the next cycle as a changed address or data. A commit pointer that has gone wrong shows up as `mem_wr_valid` rising too early, or as a flush that keeps or drops the wrong stores. A lost or stale fill bit flips the load outcome the moment a load is presented, because stall, forward and bypass are all combinational. A wrong priority in the match logic only shows when two stores alias, so the stimulus keeps to a handful of word addresses and byte-enable patterns. That way repeated aliasing and partial overlaps occur in most cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    LD_IDLE    = 2'd0,
    LD_BYPASS  = 2'd1,
    LD_FORWARD = 2'd2,
    LD_STALL   = 2'd3
  } ld_outcome_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int OW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          commit_fire,
  input  logic          drain_fire,
  input  logic          flush,
  output logic [OW-1:0] head_q,
  output logic [OW-1:0] cmt_q,
  output logic [OW-1:0] tail_q,
  output logic [OW-1:0] occ,
  output logic [OW-1:0] cmt_cnt,
  output logic [OW-1:0] uncmt_cnt,
  output logic          full
);
  function automatic logic [OW-1:0] span(input logic [OW-1:0] hi, input logic [OW-1:0] lo);
    return hi - lo;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      if (drain_fire)  head_q <= head_q + OW'(1);
      if (commit_fire) cmt_q  <= cmt_q + OW'(1);
      if (flush)           tail_q <= cmt_q;
      else if (alloc_fire) tail_q <= tail_q + OW'(1);
    end
  end

  assign occ       = span(tail_q, head_q);
  assign cmt_cnt   = span(cmt_q, head_q);
  assign uncmt_cnt = span(tail_q, cmt_q);
  assign full      = (occ == OW'(DEPTH));
endmodule

// File: rtl/sb_entry_array.sv
module sb_entry_array #(
  parameter int DEPTH = 8,
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic [PW-1:0] alloc_idx,
  input  logic          fill_fire,
  input  logic [PW-1:0] fill_idx,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic [BW-1:0] fill_be,
  output logic [AW-1:0] addr_q   [DEPTH],
  output logic [DW-1:0] data_q   [DEPTH],
  output logic [BW-1:0] be_q     [DEPTH],
  output logic          filled_q [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_alloc, hit_fill;
    assign hit_alloc = alloc_fire && (alloc_idx == PW'(g));
    assign hit_fill  = fill_fire && (fill_idx == PW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)         filled_q[g] <= 1'b0;
      else if (hit_alloc) filled_q[g] <= 1'b0;
      else if (hit_fill)  filled_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit_fill) begin
        addr_q[g] <= fill_addr;
        data_q[g] <= fill_data;
        be_q[g]   <= fill_be;
      end
    end
  end
endmodule

// File: rtl/sb_load_match.sv
module sb_load_match #(
  parameter int DEPTH = 8,
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int OW = PW + 1,
  localparam int BW = DW / 8
) (
  input  logic [PW-1:0] head_idx,
  input  logic [OW-1:0] occ,
  input  logic [AW-1:0] addr_q   [DEPTH],
  input  logic [BW-1:0] be_q     [DEPTH],
  input  logic          filled_q [DEPTH],
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  output logic          hit,
  output logic [PW-1:0] sel_idx,
  output logic          any_unknown,
  output logic          covers
);
  function automatic logic lanes_overlap(input logic [BW-1:0] a, input logic [BW-1:0] b);
    return (a & b) != '0;
  endfunction

  function automatic logic lanes_cover(input logic [BW-1:0] st, input logic [BW-1:0] ld);
    return (st & ld) == ld;
  endfunction

  // Walk from oldest to youngest so that the last match seen is the youngest.
  always_comb begin
    logic [PW-1:0] slot;
    hit         = 1'b0;
    sel_idx     = '0;
    any_unknown = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_idx + PW'(k);
      if (OW'(k) < occ) begin
        if (!filled_q[slot]) begin
          any_unknown = 1'b1;
        end else if (addr_q[slot] == ld_addr && lanes_overlap(be_q[slot], ld_be)) begin
          hit     = 1'b1;
          sel_idx = slot;
        end
      end
    end
    covers = lanes_cover(be_q[sel_idx], ld_be);
  end
endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd #(
  parameter int DEPTH = 8,
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int OW = PW + 1,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [PW-1:0] alloc_tag,
  input  logic          fill_valid,
  input  logic [PW-1:0] fill_tag,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic [BW-1:0] fill_be,
  input  logic          commit_valid,
  input  logic          flush,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  output logic          ld_fwd_valid,
  output logic [DW-1:0] ld_fwd_data,
  output logic          ld_stall,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  output logic [BW-1:0] mem_rd_be,
  output logic          mem_wr_valid,
  input  logic          mem_wr_grant,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic [BW-1:0] mem_wr_be
);
  import sb_pkg::*;

  function automatic logic [DW-1:0] lane_mask(input logic [BW-1:0] be);
    logic [DW-1:0] m;
    for (int b = 0; b < BW; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  logic [OW-1:0] head_q, cmt_q, tail_q, occ, cmt_cnt, uncmt_cnt;
  logic          full;
  logic [AW-1:0] addr_q   [DEPTH];
  logic [DW-1:0] data_q   [DEPTH];
  logic [BW-1:0] be_q     [DEPTH];
  logic          filled_q [DEPTH];

  logic [PW-1:0] head_idx, cmt_idx, tail_idx, fill_age, sel_idx;
  logic          alloc_fire, commit_fire, drain_fire, fill_fire, fill_in_range;
  logic          hit, any_unknown, covers;
  ld_outcome_e   outcome;

  assign head_idx = head_q[PW-1:0];
  assign cmt_idx  = cmt_q[PW-1:0];
  assign tail_idx = tail_q[PW-1:0];

  // Events brought out as named wires for the checker.
  assign alloc_fire    = alloc_valid && !full && !flush;
  assign commit_fire   = commit_valid && !flush && (uncmt_cnt != '0) && filled_q[cmt_idx];
  assign drain_fire    = mem_wr_valid && mem_wr_grant;
  assign fill_age      = fill_tag - cmt_idx;
  assign fill_in_range = ({1'b0, fill_age} < uncmt_cnt);
  assign fill_fire     = fill_valid && fill_in_range && !filled_q[fill_tag];

  sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .commit_fire(commit_fire),
    .drain_fire (drain_fire),
    .flush      (flush),
    .head_q     (head_q),
    .cmt_q      (cmt_q),
    .tail_q     (tail_q),
    .occ        (occ),
    .cmt_cnt    (cmt_cnt),
    .uncmt_cnt  (uncmt_cnt),
    .full       (full)
  );

  sb_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_fire(alloc_fire),
    .alloc_idx (tail_idx),
    .fill_fire (fill_fire),
    .fill_idx  (fill_tag),
    .fill_addr (fill_addr),
    .fill_data (fill_data),
    .fill_be   (fill_be),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .be_q      (be_q),
    .filled_q  (filled_q)
  );

  sb_load_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .head_idx   (head_idx),
    .occ        (occ),
    .addr_q     (addr_q),
    .be_q       (be_q),
    .filled_q   (filled_q),
    .ld_addr    (ld_addr),
    .ld_be      (ld_be),
    .hit        (hit),
    .sel_idx    (sel_idx),
    .any_unknown(any_unknown),
    .covers     (covers)
  );

  always_comb begin
    if (!ld_valid)                outcome = LD_IDLE;
    else if (any_unknown)         outcome = LD_STALL;
    else if (hit && !covers)      outcome = LD_STALL;
    else if (hit)                 outcome = LD_FORWARD;
    else                          outcome = LD_BYPASS;
  end

  assign ld_fwd_valid = (outcome == LD_FORWARD);
  assign ld_stall     = (outcome == LD_STALL);
  assign mem_rd_valid = (outcome == LD_BYPASS);
  assign ld_fwd_data  = ld_fwd_valid ? (data_q[sel_idx] & lane_mask(ld_be)) : '0;
  assign mem_rd_addr  = ld_addr;
  assign mem_rd_be    = ld_be;

  assign alloc_ready  = !full;
  assign alloc_tag    = tail_idx;

  assign mem_wr_valid = (cmt_cnt != '0);
  assign mem_wr_addr  = addr_q[head_idx];
  assign mem_wr_data  = data_q[head_idx];
  assign mem_wr_be    = be_q[head_idx];
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH = 8,
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int OW = PW + 1,
  localparam int BW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_ready,
  input logic          flush,
  input logic          ld_valid,
  input logic          ld_fwd_valid,
  input logic          ld_stall,
  input logic          mem_rd_valid,
  input logic          mem_wr_valid,
  input logic          mem_wr_grant,
  input logic [AW-1:0] mem_wr_addr,
  input logic [DW-1:0] mem_wr_data,
  input logic [BW-1:0] mem_wr_be,
  input logic [OW-1:0] occ,
  input logic [OW-1:0] cmt_cnt,
  input logic [OW-1:0] uncmt_cnt,
  input logic          any_unknown,
  input logic          drain_fire
);
  p_full_blocks_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OW'(DEPTH)) |-> !alloc_ready);

  p_wr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_grant) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_be)));

  p_wr_only_committed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (cmt_cnt != '0));

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ($countones({ld_fwd_valid, mem_rd_valid, ld_stall}) == 1));

  p_no_outcome_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !(ld_fwd_valid || mem_rd_valid || ld_stall));

  p_unknown_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && any_unknown) |-> ld_stall);

  p_flush_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (uncmt_cnt == '0));

  p_flush_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cmt_cnt == $past(cmt_cnt) - OW'($past(drain_fire))));
endmodule

bind store_buffer_fwd sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_ready (alloc_ready),
  .flush       (flush),
  .ld_valid    (ld_valid),
  .ld_fwd_valid(ld_fwd_valid),
  .ld_stall    (ld_stall),
  .mem_rd_valid(mem_rd_valid),
  .mem_wr_valid(mem_wr_valid),
  .mem_wr_grant(mem_wr_grant),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_be   (mem_wr_be),
  .occ         (occ),
  .cmt_cnt     (cmt_cnt),
  .uncmt_cnt   (uncmt_cnt),
  .any_unknown (any_unknown),
  .drain_fire  (drain_fire)
);

// File: tb/store_buffer_fwd_test.sv
`timescale 1ns/1ps
module store_buffer_fwd_test;
  localparam int D  = 8;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int PW = 3;
  localparam int BW = 4;
  localparam logic [AW-1:0] A = 30'h40;
  localparam logic [AW-1:0] B = 30'h41;

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic          alloc_valid, fill_valid, commit_valid, flush, ld_valid, mem_wr_grant;
  logic [PW-1:0] fill_tag;
  logic [AW-1:0] fill_addr, ld_addr;
  logic [DW-1:0] fill_data;
  logic [BW-1:0] fill_be, ld_be;
  logic          alloc_ready, ld_fwd_valid, ld_stall, mem_rd_valid, mem_wr_valid;
  logic [PW-1:0] alloc_tag;
  logic [DW-1:0] ld_fwd_data, mem_wr_data;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [BW-1:0] mem_rd_be, mem_wr_be;

  store_buffer_fwd #(.DEPTH(D), .AW(AW), .DW(DW)) uut (.*);

  int checks = 0;
  int errors = 0;

  // Reference model: monotonic positions, slot = position mod D.
  int hd, cm, tl;
  logic [AW-1:0] m_addr [D];
  logic [DW-1:0] m_data [D];
  logic [BW-1:0] m_be   [D];
  bit            m_fill [D];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expand(logic [BW-1:0] be);
    logic [DW-1:0] m = '0;
    for (int b = 0; b < BW; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic model_load(output bit fwd, output bit rd, output bit stl,
                            output logic [DW-1:0] dat, output string tag);
    bit unk = 0, hit = 0;
    int sel = 0;
    for (int p = hd; p < tl; p++) begin
      if (!m_fill[p % D]) unk = 1;
      else if (m_addr[p % D] == ld_addr && (m_be[p % D] & ld_be) != 0) begin
        hit = 1; sel = p % D;
      end
    end
    fwd = 0; rd = 0; stl = 0; dat = '0; tag = "R5";
    if (!ld_valid) return;
    if (unk) begin stl = 1; tag = "R8"; end
    else if (hit && ((m_be[sel] & ld_be) != ld_be)) begin stl = 1; tag = "R9"; end
    else if (hit) begin fwd = 1; dat = m_data[sel] & expand(ld_be); tag = "R6/R7"; end
    else rd = 1;
  endtask

  task automatic compare_all();
    bit fwd, rd, stl;
    logic [DW-1:0] dat;
    string tag;
    check("R2 alloc_ready", alloc_ready, (tl - hd) < D);
    check("R2 alloc_tag", alloc_tag, tl % D);
    check("R4 mem_wr_valid", mem_wr_valid, cm > hd);
    if (cm > hd) begin
      check("R3 mem_wr_addr", mem_wr_addr, m_addr[hd % D]);
      check("R3 mem_wr_data", mem_wr_data, m_data[hd % D]);
      check("R3 mem_wr_be", mem_wr_be, m_be[hd % D]);
    end
    model_load(fwd, rd, stl, dat, tag);
    check({tag, " ld_fwd_valid"}, ld_fwd_valid, fwd);
    check({tag, " ld_stall"}, ld_stall, stl);
    check({tag, " mem_rd_valid"}, mem_rd_valid, rd);
    if (fwd) check({tag, " ld_fwd_data"}, ld_fwd_data, dat);
    if (rd) begin
      check("R5 mem_rd_addr", mem_rd_addr, ld_addr);
      check("R5 mem_rd_be", mem_rd_be, ld_be);
    end
  endtask

  task automatic model_step();
    int nhd = hd, ncm = cm, ntl = tl;
    if (cm > hd && mem_wr_grant) nhd = hd + 1;
    if (fill_valid) begin
      for (int p = cm; p < tl; p++)
        if (p % D == fill_tag && !m_fill[p % D]) begin
          m_fill[p % D] = 1; m_addr[p % D] = fill_addr;
          m_data[p % D] = fill_data; m_be[p % D] = fill_be;
        end
    end
    if (flush) ntl = cm;
    else begin
      if (commit_valid && cm < tl && m_fill[cm % D] && !(fill_valid && fill_tag == cm % D && 0)) ;
      if (alloc_valid && (tl - hd) < D) begin m_fill[tl % D] = 0; ntl = tl + 1; end
    end
    hd = nhd; tl = ntl;
    cm = ncm;
  endtask

  // Commit decision uses the fill state before this edge, so it is taken first.
  task automatic cycle();
    bit do_commit;
    #1;
    compare_all();
    do_commit = !flush && commit_valid && cm < tl && m_fill[cm % D];
    model_step();
    if (do_commit) cm = cm + 1;
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; fill_valid = 0; commit_valid = 0; flush = 0;
    ld_valid = 0; mem_wr_grant = 0; fill_tag = '0; fill_addr = '0;
    fill_data = '0; fill_be = '0; ld_addr = '0; ld_be = '0;
  endtask

  task automatic do_fill(logic [PW-1:0] t, logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] be);
    fill_valid = 1; fill_tag = t; fill_addr = a; fill_data = d; fill_be = be;
  endtask

  task automatic do_load(logic [AW-1:0] a, logic [BW-1:0] be);
    ld_valid = 1; ld_addr = a; ld_be = be;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hd = 0; cm = 0; tl = 0;
    for (int i = 0; i < D; i++) m_fill[i] = 0;
    idle();
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    do_load(A, 4'hF);
    #1;
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 alloc_tag", alloc_tag, 0);
    check("R1 mem_wr_valid", mem_wr_valid, 0);
    check("R1 mem_rd_valid", mem_rd_valid, 1);
    cycle();

    idle(); alloc_valid = 1; cycle();                 // slot 0, no address yet
    idle(); do_load(A, 4'hF); commit_valid = 1;
    #1 check("R8 stall on unknown address", ld_stall, 1);
    cycle();                                          // commit ignored (R11)
    idle(); do_fill(0, A, 32'h11223344, 4'h3);
    #1 check("R11 commit of unfilled ignored", mem_wr_valid, 0);
    cycle();
    idle(); do_load(A, 4'hC);
    #1 check("R12 disjoint lanes bypass", mem_rd_valid, 1);
    check("R12 disjoint lanes no forward", ld_fwd_valid, 0);
    cycle();
    idle(); do_load(A, 4'h1);
    #1 check("R6 forward valid", ld_fwd_valid, 1);
    check("R6 forward data", ld_fwd_data, 32'h00000044);
    cycle();
    idle(); do_load(A, 4'hF);
    #1 check("R9 partial overlap stall", ld_stall, 1);
    cycle();
    idle(); alloc_valid = 1; cycle();                 // slot 1
    idle(); do_fill(1, A, 32'hAABBCCDD, 4'hF); cycle();
    idle(); do_load(A, 4'h1);
    #1 check("R7 youngest data", ld_fwd_data, 32'h000000DD);
    cycle();
    idle(); commit_valid = 1; cycle();                // slot 0 committed
    idle(); flush = 1; alloc_valid = 1; cycle();      // slot 1 dropped
    idle(); do_load(B, 4'hF);
    #1 check("R10 committed kept", mem_wr_valid, 1);
    check("R10 committed data", mem_wr_data, 32'h11223344);
    check("R10 tail after flush", alloc_tag, 1);
    check("R10 dropped store no longer aliases", mem_rd_valid, 1);
    cycle();
    idle(); mem_wr_grant = 1; cycle();
    idle(); cycle();

    // R2: fill the buffer completely
    for (int i = 0; i < D; i++) begin idle(); alloc_valid = 1; cycle(); end
    idle(); alloc_valid = 1;
    #1 check("R2 full not ready", alloc_ready, 0);
    cycle();
    idle();
    #1 check("R2 tag unchanged when full", alloc_tag, 1);
    flush = 1; cycle();
    idle(); cycle();

    // Constrained random traffic on a small address set
    for (int n = 0; n < 3000; n++) begin
      idle();
      alloc_valid  = ($urandom % 100) < 45;
      commit_valid = ($urandom % 100) < 45;
      flush        = ($urandom % 100) < 3;
      mem_wr_grant = ($urandom % 100) < 50;
      if (($urandom % 100) < 60) begin
        int pick = cm;
        for (int p = tl - 1; p >= cm; p--) if (!m_fill[p % D]) pick = p;
        do_fill(($urandom % 4 == 0) ? PW'($urandom) : PW'(pick % D),
                A + AW'($urandom % 3), $urandom,
                ($urandom % 2) ? 4'hF : BW'(1 + $urandom % 15));
      end
      if (($urandom % 100) < 80)
        do_load(A + AW'($urandom % 3), ($urandom % 3 == 0) ? 4'hF : BW'(1 + $urandom % 15));
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule